// File: doc/BRIEF.md
# Serial display link byte interpreter

This block sits behind a two-wire serial slave bit engine. It interprets the byte stream that follows a start condition. The first byte is the device address. Its upper five bits are the fixed pattern `01111`, followed by two board-selected bits and then the read/write flag in bit 0. After a write-mode address, the block alternates between control bytes and payload bytes. A continuation flag in each control byte chooses one of two behaviours: exactly one payload byte follows, or every remaining byte until the bus is released is payload. A single transaction can therefore interleave individual commands with a burst of display-memory data.

Each payload byte goes to one of two places. It becomes a one-cycle command strobe, or it becomes a write into display memory at an internal pointer. That pointer steps forward after each memory write, wraps to zero past the last location, and can be loaded by the command logic. For a read-mode address, the block presents a status byte for the bit engine to shift out. Every accepted byte produces a one-cycle acknowledge request, so the bit engine knows to pull the data line low.

Top module: `i2c_ctl_byte_decoder`

## Requirements
- R1: After `start_i`, a received byte whose bits [7:1] equal `{5'b01111, addr_sel_i}` raises `ack_o` for one cycle, in the cycle after the byte strobe. Any other value gives no acknowledge, and every following byte is ignored (no acknowledge, no outputs) until the next `start_i`.
- R2: A control byte carries the continuation flag in bit 7 and the destination flag in bit 6 (0 = command, 1 = memory), and bits [5:0] must be zero. A control byte with any of bits [5:0] set is not acknowledged, and the rest of the transaction is ignored.
- R3: With continuation = 1, exactly one payload byte is taken, and the byte after it is again decoded as a control byte.
- R4: With continuation = 0, every byte up to the next `start_i` or `stop_i` is payload, routed by that control byte's destination flag.
- R5: A payload byte with destination 0 appears on `cmd_o`, with `cmd_vld_o` high for one cycle, in the cycle after its strobe.
- R6: A payload byte with destination 1 appears on `ram_wdata_o`, with `ram_we_o` high for one cycle, at `ram_addr_o` equal to the current pointer. The pointer then advances by one.
- R7: When a write lands at address `RAM_DEPTH-1`, the pointer becomes 0.
- R8: `ptr_load_i` sets the pointer to `ptr_val_i`, or to 0 if `ptr_val_i` is not below `RAM_DEPTH`. A load takes precedence over an advance in the same cycle. The write in that cycle still uses the old pointer.
- R9: Every accepted control or payload byte of a write raises `ack_o`, in the same cycle as its command or memory strobe.
- R10: A matching address with bit 0 = 1 sets `rd_act_o` until `start_i` or `stop_i`. While `rd_act_o` is high, `rd_data_o` is `status_i` if the last accepted control byte had destination 0, and `8'h00` otherwise. Outside read mode, `rd_data_o` is `8'h00`. Bytes received in read mode are ignored.
- R11: `stop_i` ends the transaction. Bytes received afterwards produce no acknowledge and no strobes. `start_i` always makes the next byte an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel_i | input | 2 | Board-selected address bits |
| start_i | input | 1 | Start or repeated start seen (one-cycle pulse) |
| stop_i | input | 1 | Stop seen (one-cycle pulse) |
| rx_vld_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte |
| ptr_load_i | input | 1 | Load the memory pointer |
| ptr_val_i | input | AW | Pointer value to load |
| status_i | input | 8 | Status byte for read mode |
| ack_o | output | 1 | Acknowledge request for the last byte |
| cmd_vld_o | output | 1 | Command byte strobe |
| cmd_o | output | 8 | Command byte |
| ram_we_o | output | 1 | Display memory write enable |
| ram_addr_o | output | AW | Display memory write address |
| ram_wdata_o | output | 8 | Display memory write data |
| rd_act_o | output | 1 | Read mode active |
| rd_data_o | output | 8 | Byte to return in read mode |

## Verification
The bench builds the block with `RAM_DEPTH = 6` and ties `addr_sel_i` to `2'b10`. The small depth means a short burst reaches the pointer wrap and a mid-burst pointer load. The non-zero select bits make a wrong-address byte differ from the accepted one in a select bit, not only in the fixed prefix. The traffic mixes single commands, a memory burst, malformed control bytes, a repeated start, and reads taken after both destination settings.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CTRL,
        ST_ONE,
        ST_STREAM,
        ST_READ,
        ST_DROP
    } dcb_state_e;

    typedef struct packed {
        dcb_state_e st;
        logic       dc;
        logic       ack;
        logic       cmd_vld;
        logic [7:0] cmd;
        logic       we;
        logic [7:0] wdata;
    } dcb_regs_t;

    localparam dcb_regs_t DCB_RST = '{
        st:      ST_IDLE,
        dc:      1'b0,
        ack:     1'b0,
        cmd_vld: 1'b0,
        cmd:     8'h00,
        we:      1'b0,
        wdata:   8'h00
    };

endpackage

// File: rtl/dcb_addr_cmp.sv
module dcb_addr_cmp #(
    parameter int          SEL_W  = 2,
    parameter logic [4:0]  PREFIX = 5'b01111
) (
    input  logic [7:0]       byte_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o,
    output logic             rd_o
);
    localparam int PFX_W = 7 - SEL_W;

    // device address: fixed prefix, then select pins, then the read flag
    assign hit_o = (byte_i[7:1] == {PREFIX[PFX_W-1:0], sel_i});
    assign rd_o  = byte_i[0];
endmodule

// File: rtl/dcb_ctrl_chk.sv
module dcb_ctrl_chk (
    input  logic [7:0] byte_i,
    output logic       ok_o,
    output logic       co_o,
    output logic       dc_o
);
    assign co_o = byte_i[7];
    assign dc_o = byte_i[6];
    assign ok_o = (byte_i[5:0] == 6'd0);
endmodule

// File: rtl/dcb_ptr.sv
module dcb_ptr #(
    parameter int RAM_DEPTH = 1296,
    parameter int AW        = $clog2(RAM_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] val_i,
    input  logic          adv_i,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] LAST = AW'(RAM_DEPTH - 1);

    logic [AW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d = (val_i > LAST) ? '0 : val_i;
        end else if (adv_i) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_ctl_byte_decoder.sv
module i2c_ctl_byte_decoder
    import dcb_pkg::*;
#(
    parameter int RAM_DEPTH = 1296,
    parameter int SEL_W     = 2,
    parameter int AW        = $clog2(RAM_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] addr_sel_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             rx_vld_i,
    input  logic [7:0]       rx_byte_i,
    input  logic             ptr_load_i,
    input  logic [AW-1:0]    ptr_val_i,
    input  logic [7:0]       status_i,
    output logic             ack_o,
    output logic             cmd_vld_o,
    output logic [7:0]       cmd_o,
    output logic             ram_we_o,
    output logic [AW-1:0]    ram_addr_o,
    output logic [7:0]       ram_wdata_o,
    output logic             rd_act_o,
    output logic [7:0]       rd_data_o
);
    dcb_regs_t     r_d, r_q;
    logic [AW-1:0] waddr_d, waddr_q;
    logic          adr_hit, adr_rd;
    logic          ctl_ok, ctl_co, ctl_dc;
    logic          ptr_adv;
    logic [AW-1:0] ptr_cur;

    dcb_addr_cmp #(.SEL_W(SEL_W)) u_adr (
        .byte_i (rx_byte_i),
        .sel_i  (addr_sel_i),
        .hit_o  (adr_hit),
        .rd_o   (adr_rd)
    );

    dcb_ctrl_chk u_ctl (
        .byte_i (rx_byte_i),
        .ok_o   (ctl_ok),
        .co_o   (ctl_co),
        .dc_o   (ctl_dc)
    );

    dcb_ptr #(.RAM_DEPTH(RAM_DEPTH), .AW(AW)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ptr_load_i),
        .val_i  (ptr_val_i),
        .adv_i  (ptr_adv),
        .ptr_o  (ptr_cur)
    );

    always_comb begin
        r_d         = r_q;
        r_d.ack     = 1'b0;
        r_d.cmd_vld = 1'b0;
        r_d.we      = 1'b0;
        waddr_d     = waddr_q;
        ptr_adv     = 1'b0;

        if (start_i) begin
            r_d.st = ST_ADDR;
        end else if (stop_i) begin
            r_d.st = ST_IDLE;
        end else if (rx_vld_i) begin
            unique case (r_q.st)
                ST_ADDR: begin
                    if (adr_hit) begin
                        r_d.ack = 1'b1;
                        r_d.st  = adr_rd ? ST_READ : ST_CTRL;
                    end else begin
                        r_d.st = ST_DROP;
                    end
                end
                ST_CTRL: begin
                    if (ctl_ok) begin
                        r_d.ack = 1'b1;
                        r_d.dc  = ctl_dc;
                        r_d.st  = ctl_co ? ST_ONE : ST_STREAM;
                    end else begin
                        r_d.st = ST_DROP;
                    end
                end
                ST_ONE, ST_STREAM: begin
                    r_d.ack = 1'b1;
                    if (r_q.dc) begin
                        r_d.we    = 1'b1;
                        r_d.wdata = rx_byte_i;
                        waddr_d   = ptr_cur;
                        ptr_adv   = 1'b1;
                    end else begin
                        r_d.cmd_vld = 1'b1;
                        r_d.cmd     = rx_byte_i;
                    end
                    if (r_q.st == ST_ONE) r_d.st = ST_CTRL;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= DCB_RST;
            waddr_q <= '0;
        end else begin
            r_q     <= r_d;
            waddr_q <= waddr_d;
        end
    end

    assign ack_o       = r_q.ack;
    assign cmd_vld_o   = r_q.cmd_vld;
    assign cmd_o       = r_q.cmd;
    assign ram_we_o    = r_q.we;
    assign ram_addr_o  = waddr_q;
    assign ram_wdata_o = r_q.wdata;
    assign rd_act_o    = (r_q.st == ST_READ);
    assign rd_data_o   = (rd_act_o && !r_q.dc) ? status_i : 8'h00;
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
    parameter int RAM_DEPTH = 1296,
    parameter int AW        = $clog2(RAM_DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stop_i,
    input logic          ack_o,
    input logic          cmd_vld_o,
    input logic          ram_we_o,
    input logic [AW-1:0] ram_addr_o,
    input logic          rd_act_o,
    input logic [7:0]    rd_data_o
);
    // R5 / R6: a payload byte goes to exactly one destination
    a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_vld_o && ram_we_o));

    // R9: every routed payload byte is acknowledged
    a_r9_payload_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o || ram_we_o) |-> ack_o);

    // R7: write address always inside the memory
    a_r7_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_addr_o <= AW'(RAM_DEPTH - 1)));

    // R11: nothing is acknowledged or routed right after a stop
    a_r11_quiet_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!ack_o && !cmd_vld_o && !ram_we_o));

    // R10: read data is zero outside read mode, and reads route nothing
    a_r10_rd_data_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act_o |-> (rd_data_o == 8'h00));
    a_r10_rd_no_route: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act_o |-> (!cmd_vld_o && !ram_we_o));
endmodule

bind i2c_ctl_byte_decoder dcb_checker #(.RAM_DEPTH(RAM_DEPTH), .AW(AW)) u_dcb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_i     (stop_i),
    .ack_o      (ack_o),
    .cmd_vld_o  (cmd_vld_o),
    .ram_we_o   (ram_we_o),
    .ram_addr_o (ram_addr_o),
    .rd_act_o   (rd_act_o),
    .rd_data_o  (rd_data_o)
);

// File: tb/tb_i2c_ctl_byte_decoder.sv
module tb_i2c_ctl_byte_decoder;
    localparam int DEPTH = 6;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    addr_sel = 2'b10;
    logic          start_p = 1'b0, stop_p = 1'b0, rx_vld = 1'b0;
    logic [7:0]    rx_byte = 8'h00;
    logic          ld = 1'b0;
    logic [AW-1:0] ldv = '0;
    logic [7:0]    status = 8'h5A;
    logic          ack, cmd_vld, we, rd_act;
    logic [7:0]    cmd, wdata, rd_data;
    logic [AW-1:0] waddr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int ptr_m = 0;

    typedef struct {
        int       kind;   // 1 command, 2 memory write
        logic [7:0] data;
        int       addr;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    i2c_ctl_byte_decoder #(.RAM_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .addr_sel_i(addr_sel),
        .start_i(start_p), .stop_i(stop_p), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
        .ptr_load_i(ld), .ptr_val_i(ldv), .status_i(status),
        .ack_o(ack), .cmd_vld_o(cmd_vld), .cmd_o(cmd),
        .ram_we_o(we), .ram_addr_o(waddr), .ram_wdata_o(wdata),
        .rd_act_o(rd_act), .rd_data_o(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pop and compare routed bytes
    always @(negedge clk) begin
        if (rst_n && (cmd_vld || we)) begin
            total++;
            if (expq.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected strobe actual cmd=%0b we=%0b expected none", cmd_vld, we);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (e.kind == 1) begin
                    if (!cmd_vld || we || cmd != e.data) begin
                        bad++;
                        $display("FAIL R5 actual cmd_vld=%0b cmd=%h expected cmd=%h", cmd_vld, cmd, e.data);
                    end
                end else begin
                    if (!we || cmd_vld || wdata != e.data || int'(waddr) != e.addr) begin
                        bad++;
                        $display("FAIL R6 actual we=%0b addr=%0d data=%h expected addr=%0d data=%h",
                                 we, waddr, wdata, e.addr, e.data);
                    end
                end
            end
        end
    end

    task automatic send(input logic [7:0] b, input bit exp_ack, input int kind,
                        input string tag, input bit do_ld = 0, input int ld_val = 0);
        @(negedge clk);
        if (kind != 0) begin
            exp_t e;
            e.kind = kind; e.data = b; e.addr = ptr_m;
            expq.push_back(e);
        end
        if (kind == 2) ptr_m = (ptr_m == DEPTH - 1) ? 0 : ptr_m + 1;
        if (do_ld) ptr_m = ld_val;
        rx_vld = 1'b1; rx_byte = b;
        ld = do_ld; ldv = AW'(ld_val);
        @(negedge clk);
        rx_vld = 1'b0; ld = 1'b0;
        chk(tag, int'(ack), int'(exp_ack));
    endtask

    task automatic evt(input bit is_start);
        @(negedge clk);
        if (is_start) start_p = 1'b1; else stop_p = 1'b1;
        @(negedge clk);
        start_p = 1'b0; stop_p = 1'b0;
    endtask

    task automatic load_ptr(input int v);
        @(negedge clk);
        ld = 1'b1; ldv = AW'(v);
        @(negedge clk);
        ld = 1'b0;
        ptr_m = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("R11 reset ack", int'(ack), 0);
        chk("R11 reset strobes", int'(cmd_vld | we), 0);
        chk("R10 reset rd_act", int'(rd_act), 0);
        chk("R10 reset rd_data", int'(rd_data), 0);
        rst_n = 1'b1;

        // mixed transaction: single command, single memory byte, burst with wrap
        load_ptr(4);
        evt(1);
        send(8'h7C, 1, 0, "R1 address match");
        send(8'h80, 1, 0, "R2 ctrl co=1 cmd");
        send(8'hA5, 1, 1, "R5 single command");
        send(8'hC0, 1, 0, "R3 next byte is control");
        send(8'h11, 1, 2, "R6 single ram byte");
        send(8'h40, 1, 0, "R4 last control");
        send(8'h22, 1, 2, "R4 stream byte");
        send(8'h33, 1, 2, "R7 wrap to zero");
        send(8'h44, 1, 2, "R9 stream ack");
        evt(0);
        send(8'h80, 0, 0, "R11 byte after stop");

        // wrong address then ignored
        evt(1);
        send(8'h78, 0, 0, "R1 wrong select bits");
        send(8'h80, 0, 0, "R1 ignored after mismatch");
        evt(0);

        // malformed control byte
        evt(1);
        send(8'h7C, 1, 0, "R1 address match");
        send(8'h81, 0, 0, "R2 bad control byte");
        send(8'h55, 0, 0, "R2 ignored after bad control");
        evt(0);

        // single command then command stream, then repeated start
        evt(1);
        send(8'h7C, 1, 0, "R1 address match");
        send(8'h80, 1, 0, "R3 ctrl co=1");
        send(8'h0F, 1, 1, "R3 one command");
        send(8'h00, 1, 0, "R3 control after single");
        send(8'h01, 1, 1, "R4 command stream");
        send(8'h02, 1, 1, "R4 command stream");
        evt(1);
        send(8'h7C, 1, 0, "R11 address after repeated start");
        send(8'hC0, 1, 0, "R11 control after address");
        send(8'h99, 1, 2, "R6 ram write after restart");
        evt(0);

        // pointer load wins over advance
        evt(1);
        send(8'h7C, 1, 0, "R1 address match");
        send(8'h40, 1, 0, "R4 ram stream");
        send(8'h77, 1, 2, "R8 write with load", 1, 0);
        send(8'h78, 1, 2, "R8 loaded pointer used");
        evt(0);

        // read after memory destination
        evt(1);
        send(8'h7D, 1, 0, "R10 read address ack");
        chk("R10 rd_act", int'(rd_act), 1);
        chk("R10 rd_data after ram dest", int'(rd_data), 0);
        send(8'h80, 0, 0, "R10 byte ignored in read");
        evt(0);
        chk("R10 rd_act cleared by stop", int'(rd_act), 0);

        // read after command destination
        evt(1);
        send(8'h7C, 1, 0, "R1 address match");
        send(8'h80, 1, 0, "R2 ctrl cmd");
        send(8'h10, 1, 1, "R5 command");
        evt(0);
        evt(1);
        send(8'h7D, 1, 0, "R10 read address ack");
        chk("R10 rd_data is status", int'(rd_data), 8'h5A);
        evt(0);

        repeat (3) @(negedge clk);
        chk("R4 all expected strobes seen", expq.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule